// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block is a small multicycle processor slice that carries out three control-transfer instructions: a call through the 16-bit address held in the register pair formed by the two highest registers, a call to a program-counter-relative target, and a return. After a one-cycle `start` pulse it fetches one 16-bit instruction from a synchronous byte-wide memory at the program counter, spends a fixed number of cycles executing it, and raises `done` for one cycle. The datapath has a 16-bit program counter, stack pointer, memory address register, instruction register and accumulator, an 8-bit memory data register, and a 32-entry byte register file with one read port, so the two target bytes of the indirect call are read in two consecutive cycles.

Calls save the address of the next instruction on a byte stack in the same memory, one byte per write through the 8-bit data register. The return reads the two bytes back. Any other instruction word sets an illegal flag and leaves the program counter and stack pointer as they were before the fetch. The register file is loaded through a separate write port.

Top module: `callret_seq`

## Requirements
- R1: After reset, `pc_dbg` is 0x0000, `sp_dbg` is 0x0FFF, and `busy`, `done` and `illegal` are all low.
- R2: The fetch takes six cycles. It reads the byte at PC into instruction bits 7:0 and the byte at PC+1 into bits 15:8 (`ir_dbg`), and it advances PC by two.
- R3: The word 0x9509 (indirect call) finishes in 6 fetch and 8 execute cycles, so `done` is high 14 rising edges after the edge that sampled `start`.
- R4: A call writes the low byte of the return address (fetch address + 2) at SP, then the high byte at SP-1. It leaves SP lowered by two, and SP changes by at most one per cycle.
- R5: The indirect call loads PC with register 31 as the high byte and register 30 as the low byte.
- R6: A word whose bits 15:12 are 0xD is a relative call. Its bits 11:0 are a two's-complement offset, and the new PC is the fetch address + 2 + that sign-extended offset. It takes 12 cycles to `done`.
- R7: The word 0x9508 (return) reads the high byte from SP+1 and the low byte from SP+2, loads PC with them, and leaves SP raised by two. It takes 14 cycles to `done`.
- R8: Any other word sets `illegal` together with `done` after 7 cycles. PC and SP then hold the values they had before the fetch.
- R9: A `start` pulse while `busy` is high has no effect, memory is never read and written in the same cycle, and PC does not move while the block is idle.
- R10: `done` is a single-cycle pulse. `illegal` stays set until the next accepted `start` and is low from the cycle after that start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one fetch/execute sequence when idle |
| mem_addr | output | 16 | Byte address for memory access (MAR) |
| mem_re | output | 1 | Read request; data is returned on `mem_rdata` in the next cycle |
| mem_we | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Write data (MDR) |
| mem_rdata | input | 8 | Read data, registered by the memory |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 5 | Register file write index |
| rf_wdata | input | 8 | Register file write data |
| busy | output | 1 | High from the cycle after an accepted start until the final execute cycle |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last instruction was not recognised |
| pc_dbg | output | 16 | Program counter |
| sp_dbg | output | 16 | Stack pointer |
| ir_dbg | output | 16 | Instruction register |

## Verification
Each result is due a fixed number of rising edges after the edge that samples `start`: 14 for the indirect call and the return, 12 for the relative call, and 7 for an illegal word. The bench counts edges from the start edge, samples `done` on each falling edge, and compares the count with these budgets. It reads PC, SP, IR, the flag and the stacked bytes only on the falling edge where `done` is seen. The vectors run back to back, so each return pops what an earlier call pushed. A second `start` that arrives mid-sequence must leave both the count and the end state unchanged.

// File: rtl/callret_pkg.sv
// Package: shared constants, opcode classes, sequencer states and the
// control word that the sequencer hands to the datapath each cycle.
package callret_pkg;

    localparam logic [15:0] OPC_ICALL     = 16'h9509;
    localparam logic [15:0] OPC_RET       = 16'h9508;
    localparam logic [3:0]  OPC_RCALL_TOP = 4'hD;

    localparam int FETCH_CYC = 6;
    localparam int EXE_ICALL = 8;
    localparam int EXE_RCALL = 6;
    localparam int EXE_RET   = 8;
    localparam int EXE_BAD   = 1;

    typedef enum logic [1:0] {CLS_ICALL, CLS_RCALL, CLS_RET, CLS_BAD} op_cls_t;
    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC} seq_st_t;

    typedef struct packed {
        logic mar_pc;
        logic mar_sp;
        logic mem_re;
        logic mem_we;
        logic pc_inc;
        logic pc_ac;
        logic pc_add;
        logic pc_back;
        logic mdr_mem;
        logic mdr_pcl;
        logic mdr_pch;
        logic ir_lo;
        logic ir_hi;
        logic sp_dec;
        logic sp_inc;
        logic ac_hi_rf;
        logic ac_lo_rf;
        logic ac_hi_mdr;
        logic ac_lo_mdr;
        logic ac_sext;
    } ctl_t;

    // Map an instruction word to its class.
    function automatic op_cls_t classify(input logic [15:0] w);
        if (w == OPC_ICALL)                return CLS_ICALL;
        else if (w == OPC_RET)             return CLS_RET;
        else if (w[15:12] == OPC_RCALL_TOP) return CLS_RCALL;
        else                               return CLS_BAD;
    endfunction

    // Fixed execute budget of each class, in cycles.
    function automatic logic [3:0] exec_len(input op_cls_t c);
        case (c)
            CLS_ICALL: return 4'(EXE_ICALL);
            CLS_RCALL: return 4'(EXE_RCALL);
            CLS_RET:   return 4'(EXE_RET);
            default:   return 4'(EXE_BAD);
        endcase
    endfunction

endpackage

// File: rtl/callret_rf.sv
// Register file: NREGS byte registers, one asynchronous read port and one
// synchronous write port. Assumes the reader tolerates a combinational path
// from the read index to the data.
module callret_rf #(
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [7:0]    wd,
    input  logic [AW-1:0] ra,
    output logic [7:0]    rd
);
    logic [7:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        // Hold one register, cleared on reset, written when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                         regs[g] <= '0;
            else if (we && wa == AW'(g))        regs[g] <= wd;
        end
    end

    // Single read port.
    assign rd = regs[ra];

endmodule

// File: rtl/callret_ctrl.sv
// Sequencer: idle / fetch / execute state machine with a step counter.
// Emits one control word per cycle. Assumes the instruction register is
// complete when the execute phase begins and stays stable during it.
module callret_ctrl
    import callret_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [15:0]   ir,
    output ctl_t          ctl,
    output logic [AW-1:0] rf_ra,
    output logic          busy,
    output logic          done,
    output logic          illegal
);
    localparam logic [AW-1:0] ZHI = AW'(NREGS - 1);
    localparam logic [AW-1:0] ZLO = AW'(NREGS - 2);

    seq_st_t    st_q;
    logic [3:0] step_q;
    logic       done_q, ill_q;
    op_cls_t    cls;

    assign cls = classify(ir);

    // Advance the state and step counter; raise done and the flag at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            step_q <= '0;
            done_q <= 1'b0;
            ill_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: if (start) begin
                    st_q   <= ST_FETCH;
                    step_q <= '0;
                    ill_q  <= 1'b0;
                end
                ST_FETCH: if (step_q == 4'(FETCH_CYC - 1)) begin
                    st_q   <= ST_EXEC;
                    step_q <= '0;
                end else begin
                    step_q <= step_q + 4'd1;
                end
                ST_EXEC: if (step_q == exec_len(cls) - 4'd1) begin
                    st_q   <= ST_IDLE;
                    step_q <= '0;
                    done_q <= 1'b1;
                    ill_q  <= (cls == CLS_BAD);
                end else begin
                    step_q <= step_q + 4'd1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Decode state, step and class into the per-cycle control word.
    always_comb begin
        ctl   = '0;
        rf_ra = '0;
        if (st_q == ST_FETCH) begin
            case (step_q)
                4'd0: ctl.mar_pc = 1'b1;
                4'd1: begin ctl.mem_re = 1'b1; ctl.pc_inc = 1'b1; end
                4'd2: begin ctl.mdr_mem = 1'b1; ctl.mar_pc = 1'b1; end
                4'd3: begin ctl.ir_lo = 1'b1; ctl.mem_re = 1'b1; ctl.pc_inc = 1'b1; end
                4'd4: ctl.mdr_mem = 1'b1;
                4'd5: ctl.ir_hi = 1'b1;
                default: ;
            endcase
        end else if (st_q == ST_EXEC) begin
            if (cls == CLS_ICALL || cls == CLS_RCALL) begin
                case (step_q)
                    4'd0: begin ctl.mar_sp = 1'b1; ctl.mdr_pcl = 1'b1; end
                    4'd1: begin ctl.mem_we = 1'b1; ctl.sp_dec = 1'b1; end
                    4'd2: begin ctl.mar_sp = 1'b1; ctl.mdr_pch = 1'b1; end
                    4'd3: begin ctl.mem_we = 1'b1; ctl.sp_dec = 1'b1; end
                    4'd4: if (cls == CLS_ICALL) begin
                              ctl.ac_hi_rf = 1'b1; rf_ra = ZHI;
                          end else begin
                              ctl.ac_sext = 1'b1;
                          end
                    4'd5: if (cls == CLS_ICALL) begin
                              ctl.ac_lo_rf = 1'b1; rf_ra = ZLO;
                          end else begin
                              ctl.pc_add = 1'b1;
                          end
                    4'd6: ctl.pc_ac = 1'b1;
                    default: ;
                endcase
            end else if (cls == CLS_RET) begin
                case (step_q)
                    4'd0: ctl.sp_inc = 1'b1;
                    4'd1: ctl.mar_sp = 1'b1;
                    4'd2: begin ctl.mem_re = 1'b1; ctl.sp_inc = 1'b1; end
                    4'd3: begin ctl.mdr_mem = 1'b1; ctl.mar_sp = 1'b1; end
                    4'd4: begin ctl.ac_hi_mdr = 1'b1; ctl.mem_re = 1'b1; end
                    4'd5: ctl.mdr_mem = 1'b1;
                    4'd6: ctl.ac_lo_mdr = 1'b1;
                    4'd7: ctl.pc_ac = 1'b1;
                    default: ;
                endcase
            end else begin
                ctl.pc_back = 1'b1;
            end
        end
    end

    assign busy    = (st_q != ST_IDLE);
    assign done    = done_q;
    assign illegal = ill_q;

endmodule

// File: rtl/callret_dp.sv
// Datapath: PC, SP, MAR, MDR, IR and AC registers, each loaded from the
// control word. Assumes at most one load source per register per cycle.
module callret_dp
    import callret_pkg::*;
#(
    parameter logic [15:0] PC_RESET = 16'h0000,
    parameter logic [15:0] SP_RESET = 16'h0FFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  ctl_t        ctl,
    input  logic [7:0]  mem_rdata,
    input  logic [7:0]  rf_rd,
    output logic [15:0] mar,
    output logic [7:0]  mdr,
    output logic [15:0] pc,
    output logic [15:0] sp,
    output logic [15:0] ir
);
    logic [15:0] ac;

    // Program counter: increment, load, relative add or rewind.
    always_ff @(posedge clk) begin
        if (!rst_n)           pc <= PC_RESET;
        else if (ctl.pc_inc)  pc <= pc + 16'd1;
        else if (ctl.pc_ac)   pc <= ac;
        else if (ctl.pc_add)  pc <= pc + ac;
        else if (ctl.pc_back) pc <= pc - 16'd2;
    end

    // Stack pointer: self increment and decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)          sp <= SP_RESET;
        else if (ctl.sp_dec) sp <= sp - 16'd1;
        else if (ctl.sp_inc) sp <= sp + 16'd1;
    end

    // Memory address register: from PC or SP.
    always_ff @(posedge clk) begin
        if (!rst_n)          mar <= '0;
        else if (ctl.mar_pc) mar <= pc;
        else if (ctl.mar_sp) mar <= sp;
    end

    // Memory data register: from memory or one byte of PC.
    always_ff @(posedge clk) begin
        if (!rst_n)           mdr <= '0;
        else if (ctl.mdr_mem) mdr <= mem_rdata;
        else if (ctl.mdr_pcl) mdr <= pc[7:0];
        else if (ctl.mdr_pch) mdr <= pc[15:8];
    end

    // Instruction register: assembled one byte at a time.
    always_ff @(posedge clk) begin
        if (!rst_n)         ir <= '0;
        else if (ctl.ir_lo) ir[7:0]  <= mdr;
        else if (ctl.ir_hi) ir[15:8] <= mdr;
    end

    // Accumulator: target built from register bytes, stack bytes or offset.
    always_ff @(posedge clk) begin
        if (!rst_n)             ac <= '0;
        else if (ctl.ac_hi_rf)  ac[15:8] <= rf_rd;
        else if (ctl.ac_lo_rf)  ac[7:0]  <= rf_rd;
        else if (ctl.ac_hi_mdr) ac[15:8] <= mdr;
        else if (ctl.ac_lo_mdr) ac[7:0]  <= mdr;
        else if (ctl.ac_sext)   ac <= {{4{ir[11]}}, ir[11:0]};
    end

endmodule

// File: rtl/callret_seq.sv
// Top: sequencer, datapath and register file wired together. Memory is
// external, byte wide, with registered read data one cycle after mem_re.
module callret_seq
    import callret_pkg::*;
#(
    parameter int          NREGS    = 32,
    parameter logic [15:0] PC_RESET = 16'h0000,
    parameter logic [15:0] SP_RESET = 16'h0FFF,
    localparam int         AW       = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [15:0]   mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          rf_we,
    input  logic [AW-1:0] rf_waddr,
    input  logic [7:0]    rf_wdata,
    output logic          busy,
    output logic          done,
    output logic          illegal,
    output logic [15:0]   pc_dbg,
    output logic [15:0]   sp_dbg,
    output logic [15:0]   ir_dbg
);
    ctl_t          ctl;
    logic [AW-1:0] rf_ra;
    logic [7:0]    rf_rd;
    logic [15:0]   ir;

    callret_ctrl #(.NREGS(NREGS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .ir(ir),
        .ctl(ctl), .rf_ra(rf_ra), .busy(busy), .done(done), .illegal(illegal)
    );

    callret_dp #(.PC_RESET(PC_RESET), .SP_RESET(SP_RESET)) u_dp (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .mem_rdata(mem_rdata),
        .rf_rd(rf_rd), .mar(mem_addr), .mdr(mem_wdata),
        .pc(pc_dbg), .sp(sp_dbg), .ir(ir)
    );

    callret_rf #(.NREGS(NREGS)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .wa(rf_waddr), .wd(rf_wdata),
        .ra(rf_ra), .rd(rf_rd)
    );

    assign mem_re = ctl.mem_re;
    assign mem_we = ctl.mem_we;
    assign ir_dbg = ir;

endmodule

// File: rtl/callret_chk.sv
// Checker: temporal properties on the top module's ports, bound below.
module callret_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_re,
    input logic        mem_we,
    input logic        busy,
    input logic        done,
    input logic        illegal,
    input logic [15:0] pc_dbg,
    input logic [15:0] sp_dbg
);
    assert_rw_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_idle_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(pc_dbg));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_sp_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_dbg != $past(sp_dbg)) |->
            ((sp_dbg == $past(sp_dbg) + 16'd1) || (sp_dbg == $past(sp_dbg) - 16'd1)));

    assert_write_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    assert_flag_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(illegal) |-> done);

endmodule

bind callret_seq callret_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_re(mem_re), .mem_we(mem_we),
    .busy(busy), .done(done), .illegal(illegal),
    .pc_dbg(pc_dbg), .sp_dbg(sp_dbg)
);

// File: tb/sim_callret_seq.sv
module sim_callret_seq;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] at;
        logic [15:0] word;
        logic [15:0] zval;
        logic [7:0]  cyc;
        logic [15:0] exp_pc;
        logic [15:0] exp_sp;
        logic        ill;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 16'h9509, 16'h0200, 8'd14, 16'h0200, 16'h0FFD, 1'b0},
        '{16'h0200, 16'hD0FE, 16'h0000, 8'd12, 16'h0300, 16'h0FFB, 1'b0},
        '{16'h0300, 16'hDF00, 16'h0000, 8'd12, 16'h0202, 16'h0FF9, 1'b0},
        '{16'h0202, 16'h9508, 16'h0000, 8'd14, 16'h0302, 16'h0FFB, 1'b0},
        '{16'h0302, 16'h9508, 16'h0000, 8'd14, 16'h0202, 16'h0FFD, 1'b0},
        '{16'h0202, 16'h9508, 16'h0000, 8'd14, 16'h0002, 16'h0FFF, 1'b0},
        '{16'h0002, 16'h1234, 16'h0000, 8'd7,  16'h0002, 16'h0FFF, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        rf_we = 1'b0;
    logic [4:0]  rf_waddr = '0;
    logic [7:0]  rf_wdata = '0;
    logic        busy, done, illegal;
    logic [15:0] pc_dbg, sp_dbg, ir_dbg;

    logic        tb_we = 1'b0;
    logic [11:0] tb_wa = '0;
    logic [7:0]  tb_wd = '0;
    logic [7:0]  mem [4096];

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    callret_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .busy(busy), .done(done), .illegal(illegal),
        .pc_dbg(pc_dbg), .sp_dbg(sp_dbg), .ir_dbg(ir_dbg)
    );

    // Byte memory model with registered read data and a bench load port.
    always @(posedge clk) begin
        if (tb_we)  mem[tb_wa] <= tb_wd;
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put_byte(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_wa = a[11:0]; tb_wd = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic set_z(input logic [15:0] z);
        @(negedge clk);
        rf_we = 1'b1; rf_waddr = 5'd31; rf_wdata = z[15:8];
        @(negedge clk);
        rf_waddr = 5'd30; rf_wdata = z[7:0];
        @(negedge clk);
        rf_we = 1'b0;
    endtask

    // Pulse start; return edges from the start edge to the one raising done.
    task automatic run_instr(output int n);
        n = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        forever begin
            @(posedge clk); n++;
            @(negedge clk);
            if (done || n > 60) break;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic [15:0] w);
        if (w == 16'h9509)       return "R3";
        else if (w == 16'h9508)  return "R7";
        else if (w[15:12] == 4'hD) return "R6";
        else                     return "R8";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R3 watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n;
        logic [15:0] sp0, ret;
        repeat (2) @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            put_byte(VECS[i].at,         VECS[i].word[7:0]);
            put_byte(VECS[i].at + 16'd1, VECS[i].word[15:8]);
        end
        do_reset();
        // R1 reset state
        chk("R1", "pc",      32'(pc_dbg),  32'h0000);
        chk("R1", "sp",      32'(sp_dbg),  32'h0FFF);
        chk("R1", "busy",    32'(busy),    32'h0);
        chk("R1", "done",    32'(done),    32'h0);
        chk("R1", "illegal", 32'(illegal), 32'h0);

        // Table walk: chained calls and returns
        for (int i = 0; i < NV; i++) begin
            set_z(VECS[i].zval);
            sp0 = sp_dbg;
            ret = VECS[i].at + 16'd2;
            run_instr(n);
            chk(tag_of(VECS[i].word), "cycles", 32'(n), 32'(VECS[i].cyc));
            chk("R2", "ir", 32'(ir_dbg), 32'(VECS[i].word));
            chk(VECS[i].word == 16'h9509 ? "R5" : tag_of(VECS[i].word), "pc",
                32'(pc_dbg), 32'(VECS[i].exp_pc));
            chk("R4", "sp", 32'(sp_dbg), 32'(VECS[i].exp_sp));
            chk("R8", "illegal", 32'(illegal), 32'(VECS[i].ill));
            if (VECS[i].word == 16'h9509 || VECS[i].word[15:12] == 4'hD) begin
                chk("R4", "pushed low",  32'(mem[sp0[11:0]]),          32'(ret[7:0]));
                chk("R4", "pushed high", 32'(mem[sp0[11:0] - 12'd1]), 32'(ret[15:8]));
            end
        end

        // R10: flag drops after an accepted start, done is one cycle wide
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R10", "illegal after start", 32'(illegal), 32'h0);
        chk("R10", "busy after start",    32'(busy),    32'h1);
        n = 1;
        while (!done && n < 60) begin @(negedge clk); n++; end
        chk("R8", "illegal again", 32'(illegal), 32'h1);
        @(negedge clk);
        chk("R10", "done width", 32'(done), 32'h0);
        chk("R10", "illegal held", 32'(illegal), 32'h1);

        // R9: second start while busy is ignored
        do_reset();
        chk("R1", "illegal cleared by reset", 32'(illegal), 32'h0);
        put_byte(16'h0000, 8'h09);
        put_byte(16'h0001, 8'h95);
        set_z(16'h0040);
        n = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (2) begin @(posedge clk); n++; @(negedge clk); end
        start = 1'b1;
        @(posedge clk); n++;
        @(negedge clk); start = 1'b0;
        while (!done && n < 60) begin @(posedge clk); n++; @(negedge clk); end
        chk("R9", "cycles with extra start", 32'(n), 32'd14);
        chk("R9", "pc",  32'(pc_dbg), 32'h0040);
        chk("R9", "sp",  32'(sp_dbg), 32'h0FFD);
        repeat (10) @(negedge clk);
        chk("R9", "idle busy", 32'(busy),   32'h0);
        chk("R9", "idle pc",   32'(pc_dbg), 32'h0040);
        chk("R4", "idle pushed low", 32'(mem[12'hFFF]), 32'h02);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule